// File: doc/BRIEF.md
# Barrel Thread Issue Scheduler

This block decides, on every clock cycle, which hardware thread of a multithreaded core may send its next instruction into a shared in-order pipeline. Each of up to `NUM_THR` threads contributes one bit to each of several per-thread vectors: an enable that marks the thread as running, a request to park the thread until an event arrives, an event-arrival strobe, an interrupt strobe, and an external hold. The block combines these with its own per-thread spacing state and a rotating priority pointer. It then issues at most one grant per cycle, given both as a one-hot vector and as an index, together with a valid flag.

A thread that has issued stays blocked until its instruction has passed the whole pipeline of `PIPE_DEPTH` stages. A lone thread therefore issues once every `PIPE_DEPTH` cycles. With at least `PIPE_DEPTH` eligible threads, every cycle carries an issue. Slots go round-robin, so eligible threads share the pipeline evenly. Parked threads take no slots until an event or an interrupt releases them.

The grant is combinational from registered state and the present inputs. The pointer, the park flags and the spacing state update on the clock edge that follows.

Top module: `barrel_issue_sched`

## Requirements
- R1: After reset no thread is parked, `grant_vld_o` is low, and the first grant goes to the lowest-numbered eligible thread.
- R2: At most one thread is granted per cycle. When `grant_vld_o` is high, `grant_oh_o` has exactly one bit set, at position `grant_idx_o`.
- R3: A thread granted in cycle t is not granted in cycles t+1 to t+`PIPE_DEPTH`-1. It is eligible again in cycle t+`PIPE_DEPTH`.
- R4: The grant goes to the first eligible thread after the previously granted thread, searching in ascending index order and wrapping from `NUM_THR`-1 to 0.
- R5: A single enabled thread, with no other thread enabled, is granted exactly once every `PIPE_DEPTH` cycles (5 by default).
- R6: With all eight threads enabled and eligible, every cycle carries a grant and each thread receives the same number of grants over any whole number of rotations.
- R7: With k eligible threads and k < `PIPE_DEPTH`, exactly k grants occur in every window of `PIPE_DEPTH` cycles. The remaining cycles have `grant_vld_o` low.
- R8: A thread whose bit in `thr_active_i` is low is never granted.
- R9: A pulse on `wait_req_i[i]` sets `waiting_o[i]` from the next cycle on. While `waiting_o[i]` is high, thread i is not granted.
- R10: A pulse on `evt_ready_i[i]` while `waiting_o[i]` is high clears it on the next edge. The thread can be granted in the following cycle.
- R11: A pulse on `evt_ready_i[i]` while `waiting_o[i]` is low is ignored. The flag stays low, and the strobe does not release a later park.
- R12: A pulse on `irq_req_i[i]` releases a parked thread in the same way as an event strobe.
- R13: A thread whose bit in `pipe_hold_i` is high is not granted in that cycle.
- R14: In a cycle with no eligible thread, `grant_vld_o` is low and `grant_oh_o` and `grant_idx_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_active_i | input | NUM_THR | Thread enabled (running) |
| wait_req_i | input | NUM_THR | Pulse: park the thread until an event arrives |
| evt_ready_i | input | NUM_THR | Pulse: the awaited event has arrived |
| irq_req_i | input | NUM_THR | Pulse: interrupt, releases a parked thread |
| pipe_hold_i | input | NUM_THR | External hold, blocks issue this cycle |
| grant_oh_o | output | NUM_THR | One-hot grant |
| grant_idx_o | output | IDXW | Index of the granted thread |
| grant_vld_o | output | 1 | A grant is present this cycle |
| waiting_o | output | NUM_THR | Thread is parked awaiting an event |

## Verification
The assertions assume that the input pulses are single-cycle strobes aimed at individual threads. They also assume that a park request and a release for the same thread do not coincide; if they do, the park wins, and the wake property excludes that case. The stimulus changes inputs only just after a rising edge and raises each strobe for exactly one cycle on one thread. It clears every strobe and hold between scenarios and lets the spacing state drain before each new scenario. Outputs are compared at the falling edge, because the grant follows the inputs combinationally.

// File: rtl/barrel_sched_pkg.sv
package barrel_sched_pkg;

   typedef enum logic [0:0] {
      SPACE_COUNTER = 1'b0,
      SPACE_SHIFT   = 1'b1
   } space_impl_e;

   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/thr_wait_ctl.sv
module thr_wait_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic wait_req_i,
   input  logic evt_ready_i,
   input  logic irq_req_i,
   output logic waiting_o
);

   logic parked_q;

   // A park request wins over a release on the same edge.
   // A release strobe only acts on a thread that is already parked.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         parked_q <= 1'b0;
      end else if (wait_req_i) begin
         parked_q <= 1'b1;
      end else if (parked_q && (evt_ready_i || irq_req_i)) begin
         parked_q <= 1'b0;
      end
   end

   assign waiting_o = parked_q;

endmodule

// File: rtl/thr_space_ctl.sv
module thr_space_ctl
   import barrel_sched_pkg::*;
#(
   parameter int          PIPE_DEPTH = 5,
   parameter space_impl_e SPACE_IMPL = SPACE_COUNTER
) (
   input  logic clk,
   input  logic rst_n,
   input  logic issue_i,
   output logic busy_o
);

   generate
      if (SPACE_IMPL == SPACE_COUNTER) begin : g_cnt
         localparam int CW = $clog2(PIPE_DEPTH);
         localparam logic [CW-1:0] RELOAD = CW'(PIPE_DEPTH - 1);
         logic [CW-1:0] left_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               left_q <= '0;
            end else if (issue_i) begin
               left_q <= RELOAD;
            end else if (left_q != '0) begin
               left_q <= left_q - 1'b1;
            end
         end

         assign busy_o = (left_q != '0);
      end else begin : g_shift
         localparam int SW = PIPE_DEPTH - 1;
         logic [SW-1:0] stage_q;

         // One token per in-flight instruction; it falls off the end when
         // the instruction leaves the last stage.
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               stage_q <= '0;
            end else begin
               stage_q <= (stage_q << 1) | SW'(issue_i);
            end
         end

         assign busy_o = |stage_q;
      end
   endgenerate

endmodule

// File: rtl/rr_issue_pick.sv
module rr_issue_pick #(
   parameter int NUM_THR = 8,
   parameter int IDXW    = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_THR-1:0] ready_i,
   output logic [NUM_THR-1:0] grant_oh_o,
   output logic [IDXW-1:0]    grant_idx_o,
   output logic               grant_vld_o
);

   localparam logic [IDXW-1:0] LAST_IDX = IDXW'(NUM_THR - 1);

   logic [IDXW-1:0]    last_q;
   logic [NUM_THR-1:0] oh;
   logic [IDXW-1:0]    idx;
   logic               vld;

   // Search starts one past the last winner and wraps around.
   always_comb begin
      oh  = '0;
      idx = '0;
      vld = 1'b0;
      for (int k = 0; k < NUM_THR; k++) begin
         int cand;
         cand = (int'(last_q) + 1 + k) % NUM_THR;
         if (!vld && ready_i[cand]) begin
            vld      = 1'b1;
            idx      = IDXW'(cand);
            oh[cand] = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         last_q <= LAST_IDX;
      end else if (vld) begin
         last_q <= idx;
      end
   end

   assign grant_oh_o  = oh;
   assign grant_idx_o = idx;
   assign grant_vld_o = vld;

endmodule

// File: rtl/barrel_issue_sched.sv
module barrel_issue_sched
   import barrel_sched_pkg::*;
#(
   parameter int          NUM_THR    = 8,
   parameter int          PIPE_DEPTH = 5,
   parameter space_impl_e SPACE_IMPL = SPACE_COUNTER,
   localparam int         IDXW       = idx_width(NUM_THR)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_THR-1:0] thr_active_i,
   input  logic [NUM_THR-1:0] wait_req_i,
   input  logic [NUM_THR-1:0] evt_ready_i,
   input  logic [NUM_THR-1:0] irq_req_i,
   input  logic [NUM_THR-1:0] pipe_hold_i,
   output logic [NUM_THR-1:0] grant_oh_o,
   output logic [IDXW-1:0]    grant_idx_o,
   output logic               grant_vld_o,
   output logic [NUM_THR-1:0] waiting_o
);

   generate
      if (NUM_THR < 1 || NUM_THR > 64) begin : g_bad_thr
         $error("NUM_THR must lie in 1..64");
      end
      if (PIPE_DEPTH < 2) begin : g_bad_depth
         $error("PIPE_DEPTH must be at least 2");
      end
   endgenerate

   logic [NUM_THR-1:0] parked;
   logic [NUM_THR-1:0] busy;
   logic [NUM_THR-1:0] eligible;
   logic [NUM_THR-1:0] win_oh;

   generate
      for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
         thr_wait_ctl u_wait (
            .clk         (clk),
            .rst_n       (rst_n),
            .wait_req_i  (wait_req_i[t]),
            .evt_ready_i (evt_ready_i[t]),
            .irq_req_i   (irq_req_i[t]),
            .waiting_o   (parked[t])
         );

         thr_space_ctl #(
            .PIPE_DEPTH (PIPE_DEPTH),
            .SPACE_IMPL (SPACE_IMPL)
         ) u_space (
            .clk     (clk),
            .rst_n   (rst_n),
            .issue_i (win_oh[t]),
            .busy_o  (busy[t])
         );

         assign eligible[t] = thr_active_i[t] & ~parked[t] & ~busy[t] & ~pipe_hold_i[t];
      end
   endgenerate

   rr_issue_pick #(
      .NUM_THR (NUM_THR),
      .IDXW    (IDXW)
   ) u_pick (
      .clk         (clk),
      .rst_n       (rst_n),
      .ready_i     (eligible),
      .grant_oh_o  (win_oh),
      .grant_idx_o (grant_idx_o),
      .grant_vld_o (grant_vld_o)
   );

   assign grant_oh_o = win_oh;
   assign waiting_o  = parked;

endmodule

// File: rtl/barrel_issue_sched_chk.sv
module barrel_issue_sched_chk #(
   parameter int NUM_THR    = 8,
   parameter int PIPE_DEPTH = 5,
   parameter int IDXW       = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_THR-1:0] thr_active_i,
   input logic [NUM_THR-1:0] wait_req_i,
   input logic [NUM_THR-1:0] evt_ready_i,
   input logic [NUM_THR-1:0] irq_req_i,
   input logic [NUM_THR-1:0] pipe_hold_i,
   input logic [NUM_THR-1:0] grant_oh_o,
   input logic [IDXW-1:0]    grant_idx_o,
   input logic               grant_vld_o,
   input logic [NUM_THR-1:0] waiting_o
);

   p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      grant_vld_o |-> ($countones(grant_oh_o) == 1 && grant_oh_o[grant_idx_o]));

   p_idle_r14: assert property (@(posedge clk) disable iff (!rst_n)
      !grant_vld_o |-> (grant_oh_o == '0 && grant_idx_o == '0));

   p_inactive_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_oh_o & ~thr_active_i) == '0);

   p_parked_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_oh_o & waiting_o) == '0);

   p_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_oh_o & pipe_hold_i) == '0);

   generate
      for (genvar t = 0; t < NUM_THR; t++) begin : g_t
         int since_q;

         // Cycles since this thread's last grant, saturating at PIPE_DEPTH.
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               since_q <= PIPE_DEPTH;
            end else if (grant_oh_o[t]) begin
               since_q <= 1;
            end else if (since_q < PIPE_DEPTH) begin
               since_q <= since_q + 1;
            end
         end

         p_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
            grant_oh_o[t] |-> (since_q >= PIPE_DEPTH));

         p_park_r9: assert property (@(posedge clk) disable iff (!rst_n)
            wait_req_i[t] |=> waiting_o[t]);

         p_wake_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (waiting_o[t] && (evt_ready_i[t] || irq_req_i[t]) && !wait_req_i[t])
            |=> !waiting_o[t]);

         p_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (!waiting_o[t] && !wait_req_i[t]) |=> !waiting_o[t]);
      end
   endgenerate

endmodule

bind barrel_issue_sched barrel_issue_sched_chk #(
   .NUM_THR    (NUM_THR),
   .PIPE_DEPTH (PIPE_DEPTH),
   .IDXW       (IDXW)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .thr_active_i (thr_active_i),
   .wait_req_i   (wait_req_i),
   .evt_ready_i  (evt_ready_i),
   .irq_req_i    (irq_req_i),
   .pipe_hold_i  (pipe_hold_i),
   .grant_oh_o   (grant_oh_o),
   .grant_idx_o  (grant_idx_o),
   .grant_vld_o  (grant_vld_o),
   .waiting_o    (waiting_o)
);

// File: tb/barrel_issue_sched_tb.sv
module barrel_issue_sched_tb;

   localparam int N    = 8;
   localparam int DEP  = 5;
   localparam int IW   = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  act = '0;
   logic [N-1:0]  wreq = '0;
   logic [N-1:0]  evt = '0;
   logic [N-1:0]  irq = '0;
   logic [N-1:0]  hold = '0;
   logic [N-1:0]  g_oh;
   logic [IW-1:0] g_idx;
   logic          g_vld;
   logic [N-1:0]  waiting;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   barrel_issue_sched u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .thr_active_i (act),
      .wait_req_i   (wreq),
      .evt_ready_i  (evt),
      .irq_req_i    (irq),
      .pipe_hold_i  (hold),
      .grant_oh_o   (g_oh),
      .grant_idx_o  (g_idx),
      .grant_vld_o  (g_vld),
      .waiting_o    (waiting)
   );

   task automatic chk(input bit ok, input string req, input int actual, input int expected);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
      end
   endtask

   // Advance to just after the next rising edge.
   task automatic step();
      @(posedge clk);
      #1;
   endtask

   // Sample point in the middle of the current cycle.
   task automatic mid();
      @(negedge clk);
   endtask

   // R2 holds on every sampled cycle.
   task automatic chk_shape();
      if (g_vld) chk(g_oh == (N'(1) << g_idx), "R2 onehot/index", int'(g_oh), 1 << g_idx);
      else       chk(g_oh == '0 && g_idx == '0, "R14 idle outputs", int'(g_oh), 0);
   endtask

   task automatic drain();
      act = '0; wreq = '0; evt = '0; irq = '0; hold = '0;
      repeat (DEP + 1) step();
   endtask

   task automatic t_reset();
      mid();
      chk(g_vld == 1'b0, "R1 valid after reset", g_vld, 0);
      chk(waiting == '0, "R1 nothing parked after reset", int'(waiting), 0);
      chk(g_oh == '0 && g_idx == '0, "R14 no grant with nothing enabled", int'(g_oh), 0);
      step();
      act = 8'b0110_0100;
      mid();
      chk(g_vld && g_idx == 3'd2, "R1 first grant to lowest eligible", g_idx, 2);
      step();
      drain();
   endtask

   task automatic t_single();
      int hits;
      hits = 0;
      act = 8'b0000_1000;
      for (int c = 0; c < 20; c++) begin
         mid();
         chk_shape();
         chk(g_vld == ((c % DEP) == 0), "R5 lone thread every fifth cycle", g_vld, ((c % DEP) == 0));
         if (g_vld) begin
            hits++;
            chk(g_idx == 3'd3, "R3 grant to lone thread", g_idx, 3);
         end
         step();
      end
      chk(hits == 4, "R5 grant count", hits, 4);
      drain();
   endtask

   task automatic t_all();
      int cnt [N];
      int prev;
      prev = -1;
      for (int i = 0; i < N; i++) cnt[i] = 0;
      act = '1;
      for (int c = 0; c < 3 * N; c++) begin
         mid();
         chk_shape();
         chk(g_vld == 1'b1, "R6 every cycle issues", g_vld, 1);
         if (g_vld) begin
            cnt[g_idx]++;
            if (prev >= 0)
               chk(int'(g_idx) == (prev + 1) % N, "R4 rotation order", g_idx, (prev + 1) % N);
            prev = int'(g_idx);
         end
         step();
      end
      for (int i = 0; i < N; i++) chk(cnt[i] == 3, "R6 equal share", cnt[i], 3);
      drain();
   endtask

   task automatic t_three();
      int cnt [N];
      int vc;
      vc = 0;
      for (int i = 0; i < N; i++) cnt[i] = 0;
      act = 8'b0101_0010;
      for (int c = 0; c < 3 * DEP; c++) begin
         mid();
         chk_shape();
         if (g_vld) begin
            vc++;
            cnt[g_idx]++;
            chk(act[g_idx], "R8 only enabled threads", g_idx, 1);
         end
         chk(g_vld == ((c % DEP) < 3), "R7 idle slots", g_vld, ((c % DEP) < 3));
         step();
      end
      chk(vc == 9, "R7 three grants per window", vc, 9);
      chk(cnt[1] == 3 && cnt[4] == 3 && cnt[6] == 3, "R7 share per thread", cnt[4], 3);
      drain();
   endtask

   task automatic t_event();
      act = 8'b0000_0100;
      wreq[2] = 1'b1;
      mid();
      step();
      wreq[2] = 1'b0;
      for (int c = 0; c < 8; c++) begin
         mid();
         chk(waiting[2] == 1'b1, "R9 parked flag", waiting[2], 1);
         chk(g_vld == 1'b0, "R9 parked thread not granted", g_vld, 0);
         step();
      end
      evt[2] = 1'b1;
      mid();
      chk(waiting[2] == 1'b1 && !g_vld, "R10 not released before edge", waiting[2], 1);
      step();
      evt[2] = 1'b0;
      mid();
      chk(waiting[2] == 1'b0, "R10 released", waiting[2], 0);
      chk(g_vld && g_idx == 3'd2, "R10 granted after release", g_vld, 1);
      step();
      drain();
   endtask

   task automatic t_ignore_irq();
      act = 8'b0000_0100;
      evt[2] = 1'b1;
      step();
      evt[2] = 1'b0;
      mid();
      chk(waiting[2] == 1'b0, "R11 stray strobe ignored", waiting[2], 0);
      step();
      wreq[2] = 1'b1;
      step();
      wreq[2] = 1'b0;
      for (int c = 0; c < 6; c++) begin
         mid();
         chk(waiting[2] && !g_vld, "R11 strobe did not pre-release", g_vld, 0);
         step();
      end
      irq[2] = 1'b1;
      step();
      irq[2] = 1'b0;
      mid();
      chk(waiting[2] == 1'b0, "R12 interrupt releases", waiting[2], 1'b0);
      chk(g_vld && g_idx == 3'd2, "R12 granted after interrupt", g_idx, 2);
      step();
      drain();
   endtask

   task automatic t_hold();
      act = 8'b0010_0000;
      hold[5] = 1'b1;
      for (int c = 0; c < 4; c++) begin
         mid();
         chk(g_vld == 1'b0, "R13 held thread not granted", g_vld, 0);
         step();
      end
      hold[5] = 1'b0;
      mid();
      chk(g_vld && g_idx == 3'd5, "R13 grant once hold drops", g_idx, 5);
      step();
      drain();
   endtask

   initial begin
      repeat (3) step();
      rst_n = 1'b1;
      t_reset();
      t_single();
      t_all();
      t_three();
      t_event();
      t_ignore_irq();
      t_hold();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule